// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers interrupt requests for a processor core and offers the core one vector address at a time. There are ten maskable sources and one non-maskable powerdown request. Of the maskable sources, three come from external active-low pins, and each pin can be set to edge or level sensing. The others come from on-chip peripheral event pulses. Software sets up the block through a small write port. That port loads a mask word, a control word and a write-only force/clear word. A separate enable/disable command pair gates all servicing.

The request to the core is a valid/ready pair. `irq_valid` carries `irq_vec`, and the core answers with `irq_ack`. The transfer takes place on a rising clock edge where both are high. While `irq_valid` is high without `irq_ack`, the pending requests are held. The vector may change before acceptance, but only to a source of higher priority, and `irq_valid` never drops unless the gating conditions change. The core pulses `irq_ret` when a service routine ends. A level stack holds the priority that was active before each acceptance, so nested services unwind in order.

Priority levels are 1 to 10 for the maskable sources, 11 for powerdown and 0 for "nothing active". Mask bit b corresponds to level b+1 and to vector 4*(10-b).

Top module: `irq_vector_ctrl`

## Requirements
- R1: Reset leaves the mask word and the control word at zero. It also leaves every pending latch empty, the level stack empty, `stk_ovf` low, global enable on and `irq_valid` low.
- R2: Powerdown wins over every maskable source and has vector 0x002C. Among the maskable sources, the one with the highest mask bit index wins. Mask bit b gives vector 4*(10-b): bit 9 (external pin 2) gives 0x0004, bit 8 (host write) 0x0008, bit 7 (host read) 0x000C, bit 6 (serial 0 transmit) 0x0010, bit 5 (serial 0 receive) 0x0014, bit 4 (analog transmit) 0x0018, bit 3 (analog receive) 0x001C, bit 2 (serial 1 transmit or pin 1) 0x0020, bit 1 (serial 1 receive or pin 0) 0x0024 and bit 0 (timer) 0x0028.
- R3: A maskable request is presented only while its mask bit is 1 (`wr_sel`=0, `wr_data[9:0]`). A request that arrives while masked stays pending. Powerdown ignores the mask.
- R4: In the control word (`wr_sel`=1), bits 0, 1 and 2 set pins `ext_n[0]`, `ext_n[1]` and `ext_n[2]` to edge mode (1) or level mode (0). A synchronized falling edge in edge mode sets one pending latch, so one acceptance per edge. In level mode a low pin requests for as long as it stays low, and nothing is latched.
- R5: In the force/clear word (`wr_sel`=2), bits 7..0 force and bits 15..8 clear, with the same source order in both bytes. Bit 0 is the timer, bits 1..6 are mask bits 1..6, and bit 7 is external pin 2. A force bit sets the pending latch. A clear bit empties it.
- R6: `ien_clr` stops all servicing, powerdown included, from the next cycle on. `ien_set` restores servicing, and it wins when both commands come together.
- R7: With control bit 3 set (nesting), a request is offered only if its level is strictly above the active level.
- R8: With control bit 3 clear, nothing is offered while any service is active.
- R9: Each acceptance pushes the prior active level, and each `irq_ret` pops it back as the active level. A return on an empty stack makes the active level 0. An acceptance into a full stack sets the sticky `stk_ovf` and drops the pushed value.
- R10: An acceptance and a return in the same cycle leave the stack unchanged and make the accepted source active.
- R11: Acceptance empties the pending latch of the accepted source, and the offer then moves to the next eligible request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_n | input | 3 | External request pins, active low, asynchronous |
| dev_evt | input | 9 | Peripheral event pulses, bit b feeds mask bit b |
| pd_evt | input | 1 | Powerdown request pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 mask, 1 control, 2 force/clear |
| wr_data | input | 16 | Register write data |
| ien_set | input | 1 | Global enable command |
| ien_clr | input | 1 | Global disable command |
| irq_ack | input | 1 | Core ready; accepts the offered vector |
| irq_ret | input | 1 | Return from the current service |
| irq_valid | output | 1 | Vector offered to the core |
| irq_vec | output | 16 | Vector address of the offered source |
| stk_ovf | output | 1 | Sticky level stack overflow |

## Verification
The collision of interest is an acceptance and a return landing on the same edge. The bench nests a serial transmit request over a running timer service and raises `irq_ack` and `irq_ret` together. It then judges the outcome at the ports. A lower analog request must now be refused, which shows the transmit level is active. One further return must let that request through, which shows the stack kept only the level from before the timer.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int NSRC  = 10;
  localparam int NEXT  = 3;
  localparam int NDEV  = NSRC - 1;
  localparam int NFC   = 8;
  localparam int LVL_W = $clog2(NSRC + 2);
  localparam int VEC_W = 16;

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [VEC_W-1:0] vec_t;

  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_FC   = 2'd2,
    SEL_NONE = 2'd3
  } wsel_e;

  typedef struct packed {
    logic            nest;
    logic [NEXT-1:0] edge_md;
  } ctrl_t;

  localparam lvl_t PD_LVL = lvl_t'(NSRC + 1);

  // vector of mask bit b; b = -1 gives the powerdown vector
  function automatic vec_t vec_of(input int b);
    return vec_t'(4 * (NSRC - b));
  endfunction

  // force/clear byte to source vector: low bits map straight, top bit to pin 2
  function automatic logic [NSRC-1:0] fc_expand(input logic [NFC-1:0] x);
    logic [NSRC-1:0] r;
    r = '0;
    r[NFC-2:0] = x[NFC-2:0];
    r[NSRC-1]  = x[NFC-1];
    return r;
  endfunction
endpackage

// File: rtl/ivc_pin_sync.sv
module ivc_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic low_o,
  output logic fall_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[1:0], pin_n};
  end

  assign low_o  = ~sh_q[1];
  assign fall_o = sh_q[2] & ~sh_q[1];
endmodule

// File: rtl/ivc_pending.sv
module ivc_pending
  import ivc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDEV-1:0] dev_evt,
  input  logic [NEXT-1:0] ext_low,
  input  logic [NEXT-1:0] ext_fall,
  input  logic [NEXT-1:0] edge_md,
  input  logic [NSRC-1:0] force_v,
  input  logic [NSRC-1:0] clear_v,
  input  logic [NSRC-1:0] ack_v,
  input  logic            pd_evt,
  input  logic            pd_ack,
  output logic [NSRC-1:0] req_o,
  output logic            pd_o
);
  localparam int EXT_BIT [NEXT] = '{1, 2, NSRC - 1};

  logic [NSRC-1:0] pend_q, set_v, lvl_v;
  logic            pd_q;

  always_comb begin
    set_v = '0;
    lvl_v = '0;
    set_v[NDEV-1:0] = dev_evt;
    for (int e = 0; e < NEXT; e++) begin
      if (edge_md[e] && ext_fall[e]) set_v[EXT_BIT[e]] = 1'b1;
      if (!edge_md[e] && ext_low[e]) lvl_v[EXT_BIT[e]] = 1'b1;
    end
    set_v = set_v | force_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      pd_q   <= 1'b0;
    end else begin
      pend_q <= set_v | (pend_q & ~(ack_v | clear_v));
      pd_q   <= pd_evt | (pd_q & ~pd_ack);
    end
  end

  assign req_o = pend_q | lvl_v;
  assign pd_o  = pd_q;

  // R5
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_v[0] && !set_v[0]) |=> !pend_q[0]);
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter
  import ivc_pkg::*;
(
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] mask_i,
  input  logic            pd_i,
  output logic [NSRC-1:0] grant_o,
  output logic            pd_win_o,
  output lvl_t            lvl_o,
  output vec_t            vec_o,
  output logic            any_o
);
  logic [NSRC-1:0] eff;

  always_comb begin
    eff      = req_i & mask_i;
    grant_o  = '0;
    pd_win_o = 1'b0;
    lvl_o    = '0;
    vec_o    = '0;
    for (int b = 0; b < NSRC; b++) begin
      if (eff[b]) begin
        grant_o    = '0;
        grant_o[b] = 1'b1;
        lvl_o      = lvl_t'(b + 1);
        vec_o      = vec_of(b);
      end
    end
    if (pd_i) begin
      grant_o  = '0;
      pd_win_o = 1'b1;
      lvl_o    = PD_LVL;
      vec_o    = vec_of(-1);
    end
    any_o = pd_i | (|eff);
  end
endmodule

// File: rtl/ivc_lvl_stack.sv
module ivc_lvl_stack
  import ivc_pkg::*;
#(
  parameter int DEPTH = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  input  lvl_t push_val,
  output lvl_t top_o,
  output logic ovf_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  lvl_t             mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             do_push, do_pop, full;

  assign do_push = push & ~pop;
  assign do_pop  = pop & ~push;
  assign full    = (cnt_q == CNT_W'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (do_push) begin
      if (full) ovf_q <= 1'b1;
      else      cnt_q <= cnt_q + 1'b1;
    end else if (do_pop && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !full) mem_q[IDX_W'(cnt_q)] <= push_val;
  end

  assign top_o = (cnt_q == '0) ? '0 : mem_q[IDX_W'(cnt_q - 1'b1)];
  assign ovf_o = ovf_q;

  // R9
  overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_push && full) |=> ovf_q);
  // R9
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  // R10
  both_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(cnt_q));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int STACK_DEPTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NEXT-1:0]  ext_n,
  input  logic [NDEV-1:0]  dev_evt,
  input  logic             pd_evt,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [VEC_W-1:0] wr_data,
  input  logic             ien_set,
  input  logic             ien_clr,
  input  logic             irq_ack,
  input  logic             irq_ret,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vec,
  output logic             stk_ovf
);
  logic [NSRC-1:0] mask_q;
  ctrl_t           ctrl_q;
  logic            gie_q;
  lvl_t            act_q;

  logic [NEXT-1:0] ext_low, ext_fall;
  logic [NSRC-1:0] force_v, clear_v, ack_v, req, grant;
  logic            pd_pend, pd_win, any, eligible, take;
  lvl_t            win_lvl, stk_top;
  vec_t            win_vec;
  wsel_e           sel;

  assign sel = wsel_e'(wr_sel);

  for (genvar p = 0; p < NEXT; p++) begin : g_pin
    ivc_pin_sync u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_n (ext_n[p]),
      .low_o (ext_low[p]),
      .fall_o(ext_fall[p])
    );
  end

  always_comb begin
    force_v = '0;
    clear_v = '0;
    if (wr_en && sel == SEL_FC) begin
      force_v = fc_expand(wr_data[NFC-1:0]);
      clear_v = fc_expand(wr_data[2*NFC-1:NFC]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ctrl_q <= '0;
      gie_q  <= 1'b1;
    end else begin
      if (wr_en && sel == SEL_MASK) mask_q <= wr_data[NSRC-1:0];
      if (wr_en && sel == SEL_CTRL) ctrl_q <= ctrl_t'(wr_data[NEXT:0]);
      if (ien_set)      gie_q <= 1'b1;
      else if (ien_clr) gie_q <= 1'b0;
    end
  end

  ivc_pending u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .dev_evt (dev_evt),
    .ext_low (ext_low),
    .ext_fall(ext_fall),
    .edge_md (ctrl_q.edge_md),
    .force_v (force_v),
    .clear_v (clear_v),
    .ack_v   (ack_v),
    .pd_evt  (pd_evt),
    .pd_ack  (take & pd_win),
    .req_o   (req),
    .pd_o    (pd_pend)
  );

  ivc_arbiter u_arb (
    .req_i   (req),
    .mask_i  (mask_q),
    .pd_i    (pd_pend),
    .grant_o (grant),
    .pd_win_o(pd_win),
    .lvl_o   (win_lvl),
    .vec_o   (win_vec),
    .any_o   (any)
  );

  assign eligible  = ctrl_q.nest ? (win_lvl > act_q) : (act_q == '0);
  assign irq_valid = gie_q & any & eligible;
  assign irq_vec   = win_vec;
  assign take      = irq_valid & irq_ack;
  assign ack_v     = take ? grant : '0;

  ivc_lvl_stack #(.DEPTH(STACK_DEPTH)) u_stk (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (take),
    .pop     (irq_ret),
    .push_val(act_q),
    .top_o   (stk_top),
    .ovf_o   (stk_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       act_q <= '0;
    else if (take)    act_q <= win_lvl;
    else if (irq_ret) act_q <= stk_top;
  end

  // R6
  global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_clr && !ien_set) |=> !irq_valid);
  // R8
  serial_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !ctrl_q.nest) |-> (act_q == '0));
  // R7
  strict_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (win_lvl > act_q));
  // R10
  accept_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (act_q == $past(win_lvl)));
  // R2
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant, pd_win}));
  // R3
  masked_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> ((grant & mask_q) == grant));
endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
  import ivc_pkg::*;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NEXT-1:0] ext_n = '1;
  logic [NDEV-1:0] dev_evt = '0;
  logic            pd_evt = 1'b0;
  logic            wr_en = 1'b0;
  logic [1:0]      wr_sel = 2'd3;
  logic [15:0]     wr_data = '0;
  logic            ien_set = 1'b0;
  logic            ien_clr = 1'b0;
  logic            irq_ack = 1'b0;
  logic            irq_ret = 1'b0;
  logic            irq_valid;
  logic [15:0]     irq_vec;
  logic            stk_ovf;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  irq_vector_ctrl #(.STACK_DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_n(ext_n), .dev_evt(dev_evt), .pd_evt(pd_evt),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .ien_set(ien_set),
    .ien_clr(ien_clr), .irq_ack(irq_ack), .irq_ret(irq_ret),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .stk_ovf(stk_ovf)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // monitor: every accepted vector is compared with the scoreboard head
  always @(negedge clk) begin
    logic [15:0] e;
    string t;
    #2;
    if (rst_n && irq_valid && irq_ack) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected acceptance", irq_vec, 0);
      else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(irq_vec == e, t, irq_vec, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wreg(input logic [1:0] s, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    cyc(1);
    wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  task automatic dev(input logic [NDEV-1:0] bits);
    dev_evt = bits;
    cyc(1);
    dev_evt = '0;
  endtask

  task automatic ret();
    irq_ret = 1'b1;
    cyc(1);
    irq_ret = 1'b0;
  endtask

  task automatic idle(input string tag);
    cyc(4);
    #3;
    chk(irq_valid == 1'b0, tag, irq_valid, 0);
    cyc(1);
  endtask

  // driver: queue the expectation, then accept once the offer appears
  task automatic take(input logic [15:0] v, input string tag, input bit with_ret = 1'b0);
    bit seen = 1'b0;
    exp_q.push_back(v);
    tag_q.push_back(tag);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (irq_valid) begin
        seen = 1'b1;
        break;
      end
    end
    if (!seen) begin
      chk(1'b0, {tag, " never offered"}, 0, v);
      void'(exp_q.pop_back());
      void'(tag_q.pop_back());
      cyc(1);
    end else begin
      #1;
      irq_ack = 1'b1;
      irq_ret = with_ret;
      @(posedge clk);
      #1;
      irq_ack = 1'b0;
      irq_ret = 1'b0;
    end
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    #3;
    chk(irq_valid == 1'b0, "R1 no offer after reset", irq_valid, 0);
    chk(stk_ovf == 1'b0, "R1 overflow clear after reset", stk_ovf, 0);
    cyc(1);

    // R3: mask is zero after reset, timer event waits
    dev(9'h001);
    idle("R3 masked timer held back");
    wreg(2'd0, 16'h03FF);
    dev(9'h120);
    take(16'h0008, "R2 host write first");
    idle("R8 serial mode blocks while active");
    ret();
    take(16'h0014, "R2 serial 0 receive next");
    ret();
    take(16'h0028, "R3 timer pending while masked");
    ret();
    idle("R11 acceptance empties latches");

    // R2: powerdown over a maskable source
    pd_evt = 1'b1; dev_evt = 9'h001;
    cyc(1);
    pd_evt = 1'b0; dev_evt = '0;
    take(16'h002C, "R2 powerdown wins");
    ret();
    take(16'h0028, "R2 timer after powerdown");
    ret();

    // R3: powerdown with everything masked
    wreg(2'd0, 16'h0000);
    pd_evt = 1'b1; cyc(1); pd_evt = 1'b0;
    take(16'h002C, "R3 powerdown ignores mask");
    ret();

    // R6: global disable blocks powerdown
    ien_clr = 1'b1; cyc(1); ien_clr = 1'b0;
    pd_evt = 1'b1; cyc(1); pd_evt = 1'b0;
    idle("R6 disabled blocks powerdown");
    ien_set = 1'b1; cyc(1); ien_set = 1'b0;
    take(16'h002C, "R6 re-enabled");
    ret();

    // R4: edge then level sensing on pin 2
    wreg(2'd0, 16'h03FF);
    wreg(2'd1, 16'h0004);
    ext_n[2] = 1'b0;
    take(16'h0004, "R4 edge pin 2");
    ret();
    idle("R4 one acceptance per edge");
    ext_n[2] = 1'b1;
    cyc(3);
    wreg(2'd1, 16'h0000);
    ext_n[2] = 1'b0;
    take(16'h0004, "R4 level pin 2");
    ret();
    take(16'h0004, "R4 level still low");
    ret();
    ext_n[2] = 1'b1;
    idle("R4 level released");

    // R5: force and clear bytes
    wreg(2'd2, 16'h0001);
    take(16'h0028, "R5 force timer");
    ret();
    wreg(2'd2, 16'h0080);
    take(16'h0004, "R5 force pin 2");
    ret();
    wreg(2'd0, 16'h0000);
    dev(9'h040);
    wreg(2'd2, 16'h4000);
    wreg(2'd0, 16'h03FF);
    idle("R5 clear cancels serial 0 transmit");

    // R7: nesting
    wreg(2'd1, 16'h0008);
    dev(9'h001);
    take(16'h0028, "R7 timer");
    dev(9'h008);
    take(16'h001C, "R7 higher preempts");
    dev(9'h002);
    idle("R7 lower held");
    dev(9'h008);
    idle("R7 equal held");
    ret();
    take(16'h001C, "R7 after return");
    ret();
    take(16'h0024, "R7 next in line");
    ret();
    ret();
    idle("R7 drained");

    // R10: acceptance and return on one edge
    dev(9'h001);
    take(16'h0028, "R10 timer");
    dev(9'h040);
    take(16'h0010, "R10 accept with return", 1'b1);
    dev(9'h008);
    idle("R10 accepted level active");
    ret();
    take(16'h001C, "R10 stack kept level 0");
    ret();
    idle("R10 timer not repeated");

    // R9: overflow with a depth of 4
    dev(9'h001); take(16'h0028, "R9 push 1");
    dev(9'h002); take(16'h0024, "R9 push 2");
    dev(9'h004); take(16'h0020, "R9 push 3");
    dev(9'h008); take(16'h001C, "R9 push 4");
    chk(stk_ovf == 1'b0, "R9 full without overflow", stk_ovf, 0);
    dev(9'h010); take(16'h0018, "R9 push into full");
    chk(stk_ovf == 1'b1, "R9 overflow flag", stk_ovf, 1);
    ret();
    dev(9'h008);
    take(16'h001C, "R9 dropped push lost level 4");
    repeat (5) ret();
    idle("R9 drained");
    chk(stk_ovf == 1'b1, "R9 overflow sticky", stk_ovf, 1);

    cyc(2);
    while (exp_q.size() != 0) begin
      chk(1'b0, {tag_q.pop_front(), " not accepted"}, 0, exp_q.pop_front());
    end
    finish_up();
  end
endmodule